// File: doc/BRIEF.md
# Display Power State Controller

This block tracks the power state of a display-type peripheral and carries out state changes that an external power manager requests. There are three states: OFF (dark), VIEW (panel active, light off) and GLOW (panel active with the backlight on). Moving from one state to another is not free. Each directed edge between two states has its own latency, counted in ticks of a prescaled enable input. The block stays busy until that latency has run out. While no request arrives, the block holds its state and does nothing.

The block reports three things: the state it is in now, a busy flag for the duration of a transition, and a power code that downstream logic can add up to estimate energy. The power code is the power of the current state. During a transition it is the larger of the powers of the source and destination states. A request that arrives during a transition is kept in a single pending slot and is started as soon as the running transition ends. A newer request replaces the one held. The power manager decides which states to request; this block only carries out the requests.

The FSM has two states. FS_REST means no transition is running. FS_MOVE means a transition is running. The FS_REST→FS_MOVE edge is taken on an accepted request. The FS_MOVE→FS_REST edge is taken on expiry when nothing is pending. The FS_MOVE→FS_MOVE edge is taken on expiry with a pending request, which chains a new transition.

Top module: `psm_ctrl`

## Requirements
- R1: After reset, cur_state is OFF (0), busy is 0 and power_code is 0.
- R2: State codes on req_state and cur_state are 0 = OFF, 1 = VIEW, 2 = GLOW. A request with code 3 is ignored: no busy, no state change, and it never becomes pending.
- R3: A request accepted while idle is one that has req_valid high, a legal code and a code different from cur_state. It raises busy at the next clock edge. cur_state keeps the source state until the transition ends.
- R4: Busy stays high for exactly the latency of the edge taken, in ticks. The edge latencies are: OFF→VIEW 110, VIEW→OFF 100, VIEW→GLOW 5, GLOW→VIEW 1, GLOW→OFF 1, OFF→GLOW 1 (the defaults, in 0.1 ms ticks).
- R5: A transition advances only on clocks where tick_en is high. With tick_en low, busy stays high and cur_state does not change.
- R6: A request for the state the block is already in is ignored while idle: busy stays 0.
- R7: While idle, power_code is 0 in OFF, 50 in VIEW and 150 in GLOW.
- R8: While busy, power_code is the larger of the source and destination state powers.
- R9: A legal request received during a transition is held. When the transition ends, if the held state differs from the state just reached, the new transition starts in the same cycle and busy stays high with no gap.
- R10: Only the most recent request received during a transition is kept. A newer request replaces the older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled time-base enable, one tick per high cycle |
| req_valid | input | 1 | Power manager request strobe |
| req_state | input | 2 | Requested state code |
| cur_state | output | 2 | Current state code |
| busy | output | 1 | Transition in progress |
| power_code | output | PW (8) | Power level of the state, in mW |

## Verification
The bench builds the block with its default parameters. The latencies of 110, 100, 5 and 1 ticks and the power codes of 0/50/150 are therefore checked exactly as specified. tick_en is held high in most tests, so every latency maps to the same number of clock cycles, and a run of all six edges stays well under the cycle budget. Dropping tick_en in a dedicated test shows the stall. The long OFF→VIEW edge leaves enough cycles in which to inject a pending request, and then a second one that replaces it.

// File: rtl/psm_pkg.sv
package psm_pkg;
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_VIEW = 2'd1,
        PS_GLOW = 2'd2
    } pstate_e;

    typedef enum logic {
        FS_REST = 1'b0,
        FS_MOVE = 1'b1
    } fsm_e;
endpackage

// File: rtl/psm_lat_lut.sv
module psm_lat_lut
    import psm_pkg::*;
#(
    parameter int CW             = 7,
    parameter int LAT_OFF_VIEW   = 110,
    parameter int LAT_VIEW_OFF   = 100,
    parameter int LAT_VIEW_GLOW  = 5,
    parameter int LAT_GLOW_VIEW  = 1,
    parameter int LAT_GLOW_OFF   = 1,
    parameter int LAT_OFF_GLOW   = 1
) (
    input  pstate_e         src,
    input  pstate_e         dst,
    output logic [CW-1:0]   lat
);
    always_comb begin
        case ({src, dst})
            {PS_OFF,  PS_VIEW}: lat = CW'(LAT_OFF_VIEW);
            {PS_VIEW, PS_OFF }: lat = CW'(LAT_VIEW_OFF);
            {PS_VIEW, PS_GLOW}: lat = CW'(LAT_VIEW_GLOW);
            {PS_GLOW, PS_VIEW}: lat = CW'(LAT_GLOW_VIEW);
            {PS_GLOW, PS_OFF }: lat = CW'(LAT_GLOW_OFF);
            {PS_OFF,  PS_GLOW}: lat = CW'(LAT_OFF_GLOW);
            default:            lat = CW'(1);
        endcase
    end
endmodule

// File: rtl/psm_tick_timer.sv
module psm_tick_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick_en,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (load)                  cnt <= load_val;
        else if (tick_en && cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign expire = tick_en && (cnt == CW'(1));

    // R5
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cnt));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt <= $past(cnt));
endmodule

// File: rtl/psm_pend_slot.sv
module psm_pend_slot
    import psm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  pstate_e wr_st,
    input  logic    clr,
    output logic    vld,
    output pstate_e st
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            st  <= PS_OFF;
        end else if (clr) begin
            vld <= 1'b0;
        end else if (wr) begin
            vld <= 1'b1;
            st  <= wr_st;
        end
    end

    // R10
    pend_latest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (vld && st == $past(wr_st)));
endmodule

// File: rtl/psm_ctrl.sv
module psm_ctrl
    import psm_pkg::*;
#(
    parameter int PW             = 8,
    parameter int PWR_OFF        = 0,
    parameter int PWR_VIEW       = 50,
    parameter int PWR_GLOW       = 150,
    parameter int LAT_OFF_VIEW   = 110,
    parameter int LAT_VIEW_OFF   = 100,
    parameter int LAT_VIEW_GLOW  = 5,
    parameter int LAT_GLOW_VIEW  = 1,
    parameter int LAT_GLOW_OFF   = 1,
    parameter int LAT_OFF_GLOW   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          req_valid,
    input  logic [1:0]    req_state,
    output logic [1:0]    cur_state,
    output logic          busy,
    output logic [PW-1:0] power_code
);
    localparam int M1      = (LAT_OFF_VIEW  > LAT_VIEW_OFF)  ? LAT_OFF_VIEW  : LAT_VIEW_OFF;
    localparam int M2      = (LAT_VIEW_GLOW > LAT_GLOW_VIEW) ? LAT_VIEW_GLOW : LAT_GLOW_VIEW;
    localparam int M3      = (LAT_GLOW_OFF  > LAT_OFF_GLOW)  ? LAT_GLOW_OFF  : LAT_OFF_GLOW;
    localparam int M12     = (M1 > M2) ? M1 : M2;
    localparam int MAX_LAT = (M12 > M3) ? M12 : M3;
    localparam int CW      = $clog2(MAX_LAT + 1);

    fsm_e    fsm_q, fsm_d;
    pstate_e cur_q, cur_d, dst_q, dst_d;
    pstate_e req_s, lut_src, lut_dst, pend_st, eff_st;
    logic    req_ok, pend_vld, eff_vld, pend_wr, pend_clr, ld, expire;
    logic [CW-1:0] lat;

    function automatic logic [PW-1:0] lvl(pstate_e s);
        case (s)
            PS_VIEW: return PW'(PWR_VIEW);
            PS_GLOW: return PW'(PWR_GLOW);
            default: return PW'(PWR_OFF);
        endcase
    endfunction

    assign req_s   = pstate_e'(req_state);
    assign req_ok  = req_valid && (req_state != 2'd3);
    assign eff_vld = req_ok || pend_vld;
    assign eff_st  = req_ok ? req_s : pend_st;

    psm_lat_lut #(
        .CW(CW), .LAT_OFF_VIEW(LAT_OFF_VIEW), .LAT_VIEW_OFF(LAT_VIEW_OFF),
        .LAT_VIEW_GLOW(LAT_VIEW_GLOW), .LAT_GLOW_VIEW(LAT_GLOW_VIEW),
        .LAT_GLOW_OFF(LAT_GLOW_OFF), .LAT_OFF_GLOW(LAT_OFF_GLOW)
    ) u_lut (
        .src(lut_src), .dst(lut_dst), .lat(lat)
    );

    psm_tick_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(lat),
        .tick_en(tick_en), .expire(expire)
    );

    psm_pend_slot u_pend (
        .clk(clk), .rst_n(rst_n), .wr(pend_wr), .wr_st(req_s),
        .clr(pend_clr), .vld(pend_vld), .st(pend_st)
    );

    // next-state logic
    always_comb begin
        fsm_d    = fsm_q;
        cur_d    = cur_q;
        dst_d    = dst_q;
        ld       = 1'b0;
        lut_src  = cur_q;
        lut_dst  = req_s;
        pend_wr  = 1'b0;
        pend_clr = 1'b0;
        unique case (fsm_q)
            FS_REST: begin
                if (req_ok && req_s != cur_q) begin
                    fsm_d = FS_MOVE;
                    dst_d = req_s;
                    ld    = 1'b1;
                end
            end
            FS_MOVE: begin
                if (expire) begin
                    cur_d    = dst_q;
                    pend_clr = 1'b1;
                    if (eff_vld && eff_st != dst_q) begin
                        dst_d   = eff_st;
                        lut_src = dst_q;
                        lut_dst = eff_st;
                        ld      = 1'b1;
                    end else begin
                        fsm_d = FS_REST;
                    end
                end else if (req_ok) begin
                    pend_wr = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= FS_REST;
            cur_q <= PS_OFF;
            dst_q <= PS_OFF;
        end else begin
            fsm_q <= fsm_d;
            cur_q <= cur_d;
            dst_q <= dst_d;
        end
    end

    // outputs
    always_comb begin
        cur_state = cur_q;
        busy      = (fsm_q == FS_MOVE);
        if (fsm_q == FS_MOVE)
            power_code = (lvl(cur_q) > lvl(dst_q)) ? lvl(cur_q) : lvl(dst_q);
        else
            power_code = lvl(cur_q);
    end

    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state != 2'd3);

    // R3
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> cur_state == $past(cur_state));

    // R6
    same_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_state == cur_state) |=> !busy);

    // R8
    busy_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (power_code >= lvl(cur_q) && power_code >= lvl(dst_q)));

    // R9
    done_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cur_state != $past(cur_state));
endmodule

// File: tb/psm_ctrl_tb.sv
`timescale 1ns/1ps
module psm_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_state = 2'd0;
    logic [1:0] cur_state;
    logic       busy;
    logic [7:0] power_code;

    int n_run = 0;
    int n_fail = 0;
    int bcount = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    psm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
        .req_state(req_state), .cur_state(cur_state), .busy(busy),
        .power_code(power_code)
    );

    typedef struct packed {
        logic [1:0]  req;
        logic [15:0] lat;
        logic [7:0]  p_move;
        logic [7:0]  p_end;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{req: 2'd1, lat: 16'd110, p_move: 8'd50,  p_end: 8'd50},
        '{req: 2'd2, lat: 16'd5,   p_move: 8'd150, p_end: 8'd150},
        '{req: 2'd1, lat: 16'd1,   p_move: 8'd150, p_end: 8'd50},
        '{req: 2'd0, lat: 16'd100, p_move: 8'd50,  p_end: 8'd0},
        '{req: 2'd2, lat: 16'd1,   p_move: 8'd150, p_end: 8'd150},
        '{req: 2'd0, lat: 16'd1,   p_move: 8'd150, p_end: 8'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [1:0] s);
        if (busy) bcount++;
        req_valid = 1'b1;
        req_state = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) begin
            bcount++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 state", cur_state, 0);
        check("R1 busy", busy, 0);
        check("R1 power", power_code, 0);

        // R4 R7 R8 all six edges from the table
        foreach (VECS[i]) begin
            bcount = 0;
            pulse_req(VECS[i].req);
            check("R3 busy rise", busy, 1);
            check("R8 move power", power_code, VECS[i].p_move);
            wait_idle();
            check("R4 latency", bcount, VECS[i].lat);
            check("R7 end state", cur_state, VECS[i].req);
            check("R7 end power", power_code, VECS[i].p_end);
        end

        // R6 same-state request ignored (now OFF)
        pulse_req(2'd0);
        check("R6 busy", busy, 0);
        check("R6 state", cur_state, 0);

        // R2 code 3 ignored
        pulse_req(2'd3);
        check("R2 busy", busy, 0);
        check("R2 state", cur_state, 0);

        // R5 tick stall: OFF->GLOW needs one tick
        tick_en = 1'b0;
        pulse_req(2'd2);
        repeat (5) @(negedge clk);
        check("R5 busy held", busy, 1);
        check("R3 source held", cur_state, 0);
        tick_en = 1'b1;
        @(negedge clk);
        check("R5 done", busy, 0);
        check("R5 state", cur_state, 2);

        // back to OFF
        pulse_req(2'd0);
        wait_idle();

        // R9 pending chained: OFF->VIEW then VIEW->GLOW, no gap
        bcount = 0;
        pulse_req(2'd1);
        pulse_req(2'd2);
        check("R2 mid state", cur_state, 0);
        wait_idle();
        check("R9 chained busy", bcount, 115);
        check("R9 end state", cur_state, 2);

        // R10 overwrite: from OFF go VIEW, hold GLOW then OFF
        pulse_req(2'd0);
        wait_idle();
        bcount = 0;
        pulse_req(2'd1);
        pulse_req(2'd2);
        pulse_req(2'd3);
        pulse_req(2'd0);
        wait_idle();
        check("R10 busy total", bcount, 210);
        check("R10 end state", cur_state, 0);
        check("R10 end power", power_code, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule